// File: doc/BRIEF.md
# Masked Bit-Flip Stimulus Generator

This block issues one wide stimulus word per clock for stress tests of a downstream trigger device. The amount of input activity is controlled through the number of bits that change from one word to the next. The data part of the word is cut into 8-bit lanes. In every lane a density setting n picks n of the 8 bit positions as flippable. A per-lane 32-bit LFSR supplies the random values for those positions.

Two 8-bit bunch-crossing counters ride at the top of the word. They advance on every issued word in every mode and are never randomised. A run input gates issue, and a load input reseeds the LFSRs and restarts the sequence. A 2-bit mode selects how the flippable bits evolve: random refill, lane-interleaved toggling, full inversion, or hold. A word counter reports how many words have been issued in the current run.

Top module: `bfs_stim_gen`

## Requirements
- R1: The word is laid out as: `stim[171:0]` data, `stim[179:172]` counter A, `stim[187:180]` counter B. Data lane k occupies bits 8k+7..8k, with lane 21 holding only the 4 bits 171..168. A lane bit j is the bit at offset j inside its lane.
- R2: After a synchronous active-low reset the data is zero, counter A is 0, counter B is 128, valid is 0 and word_count is 0. Each lane LFSR then holds the seed that R3 derives from a seed of 0.
- R3: A cycle with load high has priority over run. It sets lane k's LFSR to (seed XOR 0x9E3779B9*(k+1)) mod 2^32, or to 0x00000001 if that value is zero. It clears the data, sets counter A to 0 and counter B to 128, and clears valid, word_count and the alternate phase.
- R4: A cycle with run high and load low issues a word, and valid is high in the next cycle. With run low the word holds its value and valid is low in the next cycle.
- R5: Each issued word advances both counters by 1 modulo 256 in every mode, including the wrap from 255 to 0.
- R6: The flippable bits of a lane are lane bits 0..n-1, with n = min(density, 8). The other lane bits never change while issuing.
- R7: Mode 0 (random) loads each flippable bit j of lane k from bit j of that lane's LFSR state before the step. Every issued word steps every LFSR once, in any mode, as s' = (s >> 1) XOR (s[0] ? 0x80200003 : 0).
- R8: Mode 1 (alternate) keeps a phase bit that starts at 0 and toggles on every issued word. On each issue, lanes whose index parity equals the phase invert their flippable bits, and the other lanes keep theirs.
- R9: Mode 2 (full flip) inverts every flippable bit of every lane on each issued word.
- R10: Mode 3 (hold) leaves the data unchanged. The counters and LFSRs still advance.
- R11: word_count becomes 1 on an issue that follows a cycle without an issue. It increments on each back-to-back issue and holds while stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Issue a word this cycle |
| load | input | 1 | Reseed and restart the sequence |
| mode | input | 2 | 0 random, 1 alternate, 2 full flip, 3 hold |
| density | input | 4 | Flippable bits per lane (values above 8 act as 8) |
| seed | input | 32 | Seed applied on load |
| stim | output | 188 | Stimulus word |
| valid | output | 1 | A word was issued in the previous cycle |
| word_count | output | 32 | Words issued in the current run |

## Verification
A behavioural reference model is compared with every output on every cycle. Random mode runs at full density and at a partial density. Telling these apart shows whether the LFSR bits reach the correct lane positions and whether unmasked bits stay frozen. Alternate and full-flip runs separate per-lane parity gating from global inversion, and a density above 8 checks the clamp. A density of zero, the hold mode, a stop/restart, a load during run and a seed that forces the zero fallback in lane 0 check the gating, the count restart and the reseed path. A run of more than 256 words checks the counter wrap.

// File: rtl/bfs_pkg.sv
// Shared constants, mode encoding and LFSR helpers for the stimulus generator.
// Assumes 32-bit lane LFSRs; lane widths never exceed 32 bits.
package bfs_pkg;

    localparam int          SEED_W        = 32;
    localparam logic [31:0] LFSR_TAPS     = 32'h8020_0003;
    localparam logic [31:0] SEED_SPREAD   = 32'h9E37_79B9;
    localparam logic [31:0] SEED_FALLBACK = 32'h0000_0001;

    typedef enum logic [1:0] {
        MODE_RAND = 2'd0,
        MODE_ALT  = 2'd1,
        MODE_FULL = 2'd2,
        MODE_HOLD = 2'd3
    } flip_mode_e;

    // One right-shift Galois step of the maximal-length 32-bit LFSR.
    function automatic logic [31:0] lfsr_next(input logic [31:0] s);
        return (s >> 1) ^ (s[0] ? LFSR_TAPS : 32'h0);
    endfunction

    // Per-lane seed: spread the common seed by lane index, never zero.
    function automatic logic [31:0] lane_seed(input logic [31:0] seed, input int idx);
        logic [31:0] mix;
        mix = seed ^ (SEED_SPREAD * 32'(idx + 1));
        return (mix == 32'h0) ? SEED_FALLBACK : mix;
    endfunction

endpackage

// File: rtl/bfs_ctrl.sv
// Run control: derives the issue strobe and the valid flag, the alternate
// phase bit and the run word counter. Assumes load outranks run.
module bfs_ctrl #(
    parameter int WC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            load,
    output logic            issue_o,
    output logic            phase_o,
    output logic            valid_o,
    output logic [WC_W-1:0] count_o
);

    logic            valid_q;
    logic            phase_q;
    logic [WC_W-1:0] count_q;

    // Issue whenever run is requested and no reload is pending.
    always_comb issue_o = run & ~load;

    // Track the valid flag, the alternate phase and the run word count.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            valid_q <= 1'b0;
            phase_q <= 1'b0;
            count_q <= '0;
        end else begin
            valid_q <= issue_o;
            if (issue_o) begin
                phase_q <= ~phase_q;
                count_q <= valid_q ? count_q + 1'b1 : WC_W'(1);
            end
        end
    end

    assign phase_o = phase_q;
    assign valid_o = valid_q;
    assign count_o = count_q;

    // R4
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load) |=> valid_q);
    // R4
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !valid_q);
    // R11
    count_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && !valid_q) |=> (count_q == WC_W'(1)));
    // R11
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(count_q));

endmodule

// File: rtl/bfs_bcid.sv
// Bunch-crossing counter embedded in the stimulus word. It advances once per
// issued word and wraps at its width. Assumes load restarts it from INIT.
module bfs_bcid #(
    parameter int               CNT_W = 8,
    parameter logic [CNT_W-1:0] INIT  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             issue,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;

    // Restart on reset or load, step on each issued word.
    always_ff @(posedge clk) begin
        if (!rst_n || load) cnt_q <= INIT;
        else if (issue)     cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R5
    bcid_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !load) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
    // R5
    bcid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/bfs_lane.sv
// One data lane: its own 32-bit LFSR, a density mask and the flip update
// for the selected mode. Assumes LANE_W <= 32 and that issue excludes load.
module bfs_lane
    import bfs_pkg::*;
#(
    parameter int LANE_W   = 8,
    parameter int LANE_IDX = 0,
    parameter int DENS_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              issue,
    input  logic              phase,
    input  flip_mode_e        mode,
    input  logic [DENS_W-1:0] density,
    input  logic [SEED_W-1:0] seed,
    output logic [LANE_W-1:0] data_o
);

    localparam logic MY_PARITY = 1'(LANE_IDX % 2);

    logic [SEED_W-1:0] lfsr_q;
    logic [LANE_W-1:0] data_q;
    logic [LANE_W-1:0] mask;
    logic [LANE_W-1:0] data_d;

    // Thermometer mask: lane bits below the density are flippable.
    always_comb begin
        for (int j = 0; j < LANE_W; j++) mask[j] = (32'(j) < 32'(density));
    end

    // Next data value for the selected flip mode.
    always_comb begin
        case (mode)
            MODE_RAND: data_d = (data_q & ~mask) | (lfsr_q[LANE_W-1:0] & mask);
            MODE_ALT:  data_d = (phase == MY_PARITY) ? (data_q ^ mask) : data_q;
            MODE_FULL: data_d = data_q ^ mask;
            default:   data_d = data_q;
        endcase
    end

    // Seed on reset or load, otherwise step LFSR and data per issued word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q <= lane_seed('0, LANE_IDX);
            data_q <= '0;
        end else if (load) begin
            lfsr_q <= lane_seed(seed, LANE_IDX);
            data_q <= '0;
        end else if (issue) begin
            lfsr_q <= lfsr_next(lfsr_q);
            data_q <= data_d;
        end
    end

    assign data_o = data_q;

    // R6
    unmasked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !load) |=> (((data_q ^ $past(data_q)) & ~$past(mask)) == '0));
    // R9
    full_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !load && mode == MODE_FULL) |=> (data_q == ($past(data_q) ^ $past(mask))));
    // R10
    hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !load && mode == MODE_HOLD) |=> $stable(data_q));
    // R7
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

endmodule

// File: rtl/bfs_stim_gen.sv
// Top of the masked bit-flip stimulus generator. It tiles the data into
// lanes, instantiates the two bunch-crossing counters and the run control,
// and packs the word as {counter B, counter A, data}. Assumes DATA_W > 0.
module bfs_stim_gen
    import bfs_pkg::*;
#(
    parameter int DATA_W = 172,
    parameter int LANE_W = 8,
    parameter int CNT_W  = 8,
    parameter int WC_W   = 32,
    parameter int DENS_W = 4,
    parameter int B_INIT = 128
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run,
    input  logic                      load,
    input  logic [1:0]                mode,
    input  logic [DENS_W-1:0]         density,
    input  logic [SEED_W-1:0]         seed,
    output logic [DATA_W+2*CNT_W-1:0] stim,
    output logic                      valid,
    output logic [WC_W-1:0]           word_count
);

    localparam int LANES  = (DATA_W + LANE_W - 1) / LANE_W;
    localparam int LAST_W = DATA_W - LANE_W * (LANES - 1);

    logic             issue;
    logic             phase;
    flip_mode_e       mode_e;
    logic [DATA_W-1:0] data;
    logic [CNT_W-1:0] cnt_a;
    logic [CNT_W-1:0] cnt_b;

    // Interpret the raw mode pins as the shared mode type.
    always_comb mode_e = flip_mode_e'(mode);

    bfs_ctrl #(.WC_W(WC_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .load    (load),
        .issue_o (issue),
        .phase_o (phase),
        .valid_o (valid),
        .count_o (word_count)
    );

    bfs_bcid #(.CNT_W(CNT_W), .INIT('0)) u_bcid_a (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .issue (issue),
        .cnt_o (cnt_a)
    );

    bfs_bcid #(.CNT_W(CNT_W), .INIT(CNT_W'(B_INIT))) u_bcid_b (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .issue (issue),
        .cnt_o (cnt_b)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int W = (k == LANES - 1) ? LAST_W : LANE_W;
        bfs_lane #(.LANE_W(W), .LANE_IDX(k), .DENS_W(DENS_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load),
            .issue   (issue),
            .phase   (phase),
            .mode    (mode_e),
            .density (density),
            .seed    (seed),
            .data_o  (data[k*LANE_W +: W])
        );
    end

    assign stim = {cnt_b, cnt_a, data};

    // R5
    counters_lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !load) |=> ((cnt_b - cnt_a) == $past(cnt_b - cnt_a)));

endmodule

// File: tb/bfs_stim_gen_test.sv
module bfs_stim_gen_test;

    localparam int DATA_W = 172;
    localparam int LANES  = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        load = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [3:0]  density = 4'd0;
    logic [31:0] seed = 32'h0;
    wire  [187:0] stim;
    wire         valid;
    wire  [31:0] word_count;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bfs_stim_gen uut (
        .clk(clk), .rst_n(rst_n), .run(run), .load(load), .mode(mode),
        .density(density), .seed(seed), .stim(stim), .valid(valid),
        .word_count(word_count)
    );

    // Reference model state
    logic [31:0]       m_lfsr [LANES];
    logic [DATA_W-1:0] m_data;
    int                m_a, m_b, m_count;
    bit                m_phase, m_valid;

    function automatic logic [31:0] ref_step(logic [31:0] s);
        if (s % 2 == 1) return (s / 2) ^ 32'h8020_0003;
        return s / 2;
    endfunction

    function automatic logic [31:0] ref_seed(logic [31:0] sd, int k);
        logic [31:0] v;
        v = sd ^ (32'h9E37_79B9 * 32'(k + 1));
        if (v == 0) v = 32'h1;
        return v;
    endfunction

    task automatic m_init(logic [31:0] sd);
        for (int k = 0; k < LANES; k++) m_lfsr[k] = ref_seed(sd, k);
        m_data = '0; m_a = 0; m_b = 128; m_phase = 0; m_count = 0; m_valid = 0;
    endtask

    task automatic m_issue();
        for (int b = 0; b < DATA_W; b++) begin
            int k = b / 8;
            int j = b % 8;
            if (j < int'(density)) begin
                case (mode)
                    2'd0: m_data[b] = m_lfsr[k][j];
                    2'd1: if (k % 2 == int'(m_phase)) m_data[b] = ~m_data[b];
                    2'd2: m_data[b] = ~m_data[b];
                    default: ;
                endcase
            end
        end
        for (int k = 0; k < LANES; k++) m_lfsr[k] = ref_step(m_lfsr[k]);
        m_a = (m_a + 1) % 256;
        m_b = (m_b + 1) % 256;
        m_phase = ~m_phase;
        m_count = m_valid ? m_count + 1 : 1;
        m_valid = 1;
    endtask

    always @(posedge clk) begin
        if (!rst_n)     m_init(32'h0);
        else if (load)  m_init(seed);
        else if (run)   m_issue();
        else            m_valid = 0;
    end

    task automatic check(string tag, logic [187:0] act, logic [187:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string data_tag();
        if (!rst_n) return "R2 data";
        if (load)   return "R3 data";
        if (!run)   return "R4 data";
        case (mode)
            2'd0:    return "R7 random data";
            2'd1:    return "R8 alternate data";
            2'd2:    return "R9 full flip data";
            default: return "R10 hold data";
        endcase
    endfunction

    // Compare every output against the model (inputs still those of the last edge).
    task automatic compare_all();
        check(data_tag(), 188'(stim[171:0]), 188'(m_data));
        check("R5 counter A", 188'(stim[179:172]), 188'(m_a[7:0]));
        check("R5 counter B", 188'(stim[187:180]), 188'(m_b[7:0]));
        check("R4 valid", 188'(valid), 188'(m_valid));
        check("R11 word count", 188'(word_count), 188'(m_count));
    endtask

    task automatic cycles(int n);
        repeat (n) begin
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [187:0] snap;
        cycles(4);
        // R1 R2: reset word layout
        check("R2 reset word", stim, {8'd128, 8'd0, 172'b0});
        check("R2 reset valid", 188'(valid), 188'(0));
        rst_n = 1'b1;
        cycles(2);
        // R3: load then random at full density
        seed = 32'h1234_5678; load = 1'b1; cycles(1);
        load = 1'b0; run = 1'b1; mode = 2'd0; density = 4'd8; cycles(40);
        // R6: partial density
        density = 4'd3; cycles(40);
        // R6: zero density leaves data untouched
        snap = stim; density = 4'd0; cycles(20);
        check("R6 zero density data", 188'(stim[171:0]), 188'(snap[171:0]));
        // R4: stop holds the word
        snap = stim; run = 1'b0; cycles(5);
        check("R4 stopped word", stim, snap);
        check("R4 stopped valid", 188'(valid), 188'(0));
        // R11: restart counts from one
        run = 1'b1; mode = 2'd1; density = 4'd5; cycles(1);
        check("R11 restart count", 188'(word_count), 188'(1));
        cycles(30);
        // R9: full flip, then clamp above 8
        mode = 2'd2; density = 4'd8; cycles(20);
        density = 4'd12; cycles(10);
        // R10: hold mode
        snap = stim; mode = 2'd3; cycles(10);
        check("R10 hold data", 188'(stim[171:0]), 188'(snap[171:0]));
        // R3: load during run, seed forcing zero fallback in lane 0
        seed = 32'h9E37_79B9; load = 1'b1; cycles(1);
        check("R3 load valid", 188'(valid), 188'(0));
        check("R3 load count", 188'(word_count), 188'(0));
        check("R3 load counters", 188'(stim[187:172]), 188'({8'd128, 8'd0}));
        load = 1'b0; mode = 2'd0; density = 4'd8; cycles(300);
        // R5: counter A equals words since load modulo 256
        check("R5 wrap", 188'(stim[179:172]), 188'(8'(300)));
        run = 1'b0; cycles(2);
        finish_run();
    end

endmodule